// File: doc/BRIEF.md
# Parallel Display Bus Write Engine

This block drives an 8-bit parallel display bus in the 8080 style: active-low chip select, write strobe, read strobe and panel reset, plus a register-select line that marks a byte as command (low) or data (high). One request at a time arrives on a valid/ready port. A request names one of five operations: command byte, data byte, pixel, single-byte read, or a timed panel reset pulse.

A pixel is cut into bytes and sent most significant byte first. The colour format code sets the split: code 0 is 24-bit RGB in three bytes, code 1 is 18-bit colour in three bytes whose first byte carries only the top two bits, and code 2 is 16-bit 5-6-5 colour in two bytes. Register select keeps its last value between requests, so a stream of pixels sees it stay high. Every strobe width and wait is a count of clock cycles set by a parameter.

Top module: `disp8080_wr`

## Requirements
- R1: After reset: req_ready=1, all four active-low bus controls high, lcd_rs=0, lcd_dout=0, lcd_doe=1, rd_byte=0, and fmt_err and rd_done low.
- R2: A kind 0 request (command) drives lcd_rs low and sends req_word[7:0] as one byte. Each byte takes one setup cycle with write strobe high and the byte on lcd_dout, then WR_LO cycles with write strobe low, then WR_HI cycles with write strobe high.
- R3: A kind 1 request (data) sends req_word[7:0] as one byte in the same form as R2, with lcd_rs high.
- R4: A kind 2 request (pixel) with req_fmt=0 drives lcd_rs high and sends req_word[23:16], [15:8] and [7:0] in that order, one write strobe each.
- R5: With req_fmt=1, three bytes are sent: {6'b0, req_word[17:16]}, req_word[15:8], req_word[7:0].
- R6: With req_fmt=2, two bytes are sent: req_word[15:8] then req_word[7:0].
- R7: lcd_rs and lcd_dout keep their last driven values while the engine is idle and during reset pulses. After a pixel, lcd_rs therefore stays high.
- R8: lcd_cs_n is low only while a write or read sequence runs. req_ready is low from the cycle after acceptance until the sequence ends.
- R9: A kind 3 request (read) drives lcd_rs high and lcd_doe low. The read strobe is low for RD_LO cycles and lcd_din is captured at its rising edge. Then follow RD_WAIT cycles with the strobe high. In the first idle cycle, rd_done pulses, rd_byte holds the captured value, and lcd_doe is high again.
- R10: A kind 4 request (panel reset) drives lcd_rst_n low for RST_LO cycles, then waits RST_WAIT cycles with it high. Chip select and read strobe stay high throughout.
- R11: A pixel request with req_fmt=3, or a request with kind 5 to 7, causes no bus activity. fmt_err is high for the single cycle after acceptance, and req_ready stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request taken on this edge |
| req_kind | input | 3 | 0 command, 1 data, 2 pixel, 3 read, 4 panel reset |
| req_fmt | input | 2 | Pixel colour format code |
| req_word | input | 24 | Byte or pixel value |
| rd_byte | output | 8 | Last byte captured by a read |
| rd_done | output | 1 | One-cycle pulse when a read completes |
| fmt_err | output | 1 | One-cycle pulse on a dropped request |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_rst_n | output | 1 | Panel reset, active low |
| lcd_rs | output | 1 | Register select: 0 command, 1 data |
| lcd_dout | output | 8 | Bus data out |
| lcd_doe | output | 1 | Bus output enable |
| lcd_din | input | 8 | Bus data in |

## Verification
Four corner cases get direct stimulus: the 18-bit first byte with every upper bit of the word set, the byte order of the two multi-byte formats, a command issued straight after a pixel, and dropped requests. A design that masks the 18-bit byte wrongly would put 0xFF on the bus instead of 0x03. A design with swapped byte order would send the low byte first. A design that does not reload register select would leave it high for the command. A design that does not drop bad requests would strobe the bus when the request should be dropped. The bench also runs two reads with different input bytes and a reset pulse, so that an off-by-one in any of the strobe widths, a capture taken at the wrong edge, or chip select asserted during the reset pulse shows up as a miscompare on a specific cycle.

// File: rtl/disp8080_wr.sv
module disp8080_wr #(
  parameter int WR_LO    = 2,
  parameter int WR_HI    = 2,
  parameter int RD_LO    = 200,
  parameter int RD_WAIT  = 2000,
  parameter int RST_LO   = 3000,
  parameter int RST_WAIT = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_kind,
  input  logic [1:0]  req_fmt,
  input  logic [23:0] req_word,
  output logic [7:0]  rd_byte,
  output logic        rd_done,
  output logic        fmt_err,
  output logic        lcd_cs_n,
  output logic        lcd_wr_n,
  output logic        lcd_rd_n,
  output logic        lcd_rst_n,
  output logic        lcd_rs,
  output logic [7:0]  lcd_dout,
  output logic        lcd_doe,
  input  logic [7:0]  lcd_din
);
  localparam int M1 = (WR_LO > WR_HI) ? WR_LO : WR_HI;
  localparam int M2 = (RD_LO > RD_WAIT) ? RD_LO : RD_WAIT;
  localparam int M3 = (RST_LO > RST_WAIT) ? RST_LO : RST_WAIT;
  localparam int M4 = (M1 > M2) ? M1 : M2;
  localparam int MAXD = (M4 > M3) ? M4 : M3;
  localparam int TW = $clog2(MAXD) + 1;

  localparam logic [TW-1:0] L_WLO = TW'(WR_LO - 1);
  localparam logic [TW-1:0] L_WHI = TW'(WR_HI - 1);
  localparam logic [TW-1:0] L_RLO = TW'(RD_LO - 1);
  localparam logic [TW-1:0] L_RWT = TW'(RD_WAIT - 1);
  localparam logic [TW-1:0] L_XLO = TW'(RST_LO - 1);
  localparam logic [TW-1:0] L_XHI = TW'(RST_WAIT - 1);

  localparam logic [2:0] K_CMD = 3'd0;
  localparam logic [2:0] K_DAT = 3'd1;
  localparam logic [2:0] K_PIX = 3'd2;
  localparam logic [2:0] K_RD  = 3'd3;
  localparam logic [2:0] K_RST = 3'd4;

  typedef enum logic [2:0] {
    S_IDLE, S_SET, S_WLO, S_WHI, S_RLO, S_RWT, S_XLO, S_XHI
  } st_t;

  st_t            st;
  logic [TW-1:0]  tmr;
  logic [23:0]    sh;
  logic [1:0]     left;
  logic           rs;

  wire tdone = (tmr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tmr     <= '0;
      sh      <= '0;
      left    <= '0;
      rs      <= 1'b0;
      rd_byte <= '0;
      rd_done <= 1'b0;
      fmt_err <= 1'b0;
    end else begin
      fmt_err <= 1'b0;
      rd_done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          case (req_kind)
            K_CMD, K_DAT: begin
              rs   <= (req_kind == K_DAT);
              sh   <= {req_word[7:0], 16'h0000};
              left <= 2'd0;
              st   <= S_SET;
            end
            K_PIX: begin
              case (req_fmt)
                2'd0: begin sh <= req_word;                  left <= 2'd2; end
                2'd1: begin sh <= {6'b0, req_word[17:0]};    left <= 2'd2; end
                2'd2: begin sh <= {req_word[15:0], 8'h00};   left <= 2'd1; end
                default: fmt_err <= 1'b1;
              endcase
              if (req_fmt != 2'd3) begin
                rs <= 1'b1;
                st <= S_SET;
              end
            end
            K_RD: begin
              rs  <= 1'b1;
              tmr <= L_RLO;
              st  <= S_RLO;
            end
            K_RST: begin
              tmr <= L_XLO;
              st  <= S_XLO;
            end
            default: fmt_err <= 1'b1;
          endcase
        end
        S_SET: begin
          tmr <= L_WLO;
          st  <= S_WLO;
        end
        S_WLO: if (tdone) begin
          tmr <= L_WHI;
          st  <= S_WHI;
        end else tmr <= tmr - 1'b1;
        S_WHI: if (tdone) begin
          if (left != 2'd0) begin
            sh   <= {sh[15:0], 8'h00};
            left <= left - 1'b1;
            st   <= S_SET;
          end else st <= S_IDLE;
        end else tmr <= tmr - 1'b1;
        S_RLO: if (tdone) begin
          rd_byte <= lcd_din;
          tmr     <= L_RWT;
          st      <= S_RWT;
        end else tmr <= tmr - 1'b1;
        S_RWT: if (tdone) begin
          rd_done <= 1'b1;
          st      <= S_IDLE;
        end else tmr <= tmr - 1'b1;
        S_XLO: if (tdone) begin
          tmr <= L_XHI;
          st  <= S_XHI;
        end else tmr <= tmr - 1'b1;
        S_XHI: if (tdone) st <= S_IDLE;
               else tmr <= tmr - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign lcd_cs_n  = !(st == S_SET || st == S_WLO || st == S_WHI ||
                       st == S_RLO || st == S_RWT);
  assign lcd_wr_n  = (st != S_WLO);
  assign lcd_rd_n  = (st != S_RLO);
  assign lcd_rst_n = (st != S_XLO);
  assign lcd_doe   = !(st == S_RLO || st == S_RWT);
  assign lcd_dout  = sh[23:16];
  assign lcd_rs    = rs;

  p_wr_in_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_wr_n |-> !lcd_cs_n);
  p_ready_no_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (lcd_cs_n && lcd_wr_n && lcd_rd_n && lcd_rst_n));
  p_rd_bus_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_rd_n |-> (!lcd_doe && lcd_rs && !lcd_cs_n));
  p_rst_no_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_rst_n |-> (lcd_cs_n && lcd_rd_n));
  p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> (req_ready && lcd_cs_n && lcd_wr_n));
  p_cmd_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == K_CMD) |=>
      (!req_ready && !lcd_cs_n && !lcd_rs && lcd_wr_n));
endmodule

// File: tb/test_disp8080_wr.sv
`timescale 1ns/1ps
module test_disp8080_wr;
  localparam int WL = 2, WH = 3, RL = 5, RW = 7, XL = 9, XW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_kind = '0;
  logic [1:0] req_fmt = '0;
  logic [23:0] req_word = '0;
  logic [7:0] rd_byte, lcd_dout, lcd_din = '0;
  logic rd_done, fmt_err, lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_rst_n, lcd_rs, lcd_doe;

  always #2.5 clk = ~clk;

  disp8080_wr #(.WR_LO(WL), .WR_HI(WH), .RD_LO(RL), .RD_WAIT(RW),
                .RST_LO(XL), .RST_WAIT(XW)) i_disp8080_wr (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_fmt(req_fmt), .req_word(req_word),
    .rd_byte(rd_byte), .rd_done(rd_done), .fmt_err(fmt_err),
    .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n),
    .lcd_rst_n(lcd_rst_n), .lcd_rs(lcd_rs), .lcd_dout(lcd_dout),
    .lcd_doe(lcd_doe), .lcd_din(lcd_din));

  int vectors = 0, errors = 0;
  logic [24:0] eq[$];
  string tq[$];
  logic m_rs = 1'b0;
  logic [7:0] m_dout = '0, m_rdb = '0;

  function automatic logic [24:0] mk(logic rdy, logic cs, logic wr, logic rd,
                                     logic rst, logic oe, logic err, logic done);
    return {rdy, cs, wr, rd, rst, m_rs, oe, m_dout, err, done, m_rdb};
  endfunction

  function automatic logic [24:0] got();
    return {req_ready, lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_rst_n, lcd_rs, lcd_doe,
            lcd_dout, fmt_err, rd_done, rd_byte};
  endfunction

  task automatic put(logic [24:0] v, string t);
    eq.push_back(v);
    tq.push_back(t);
  endtask

  task automatic push_byte(logic [7:0] b, string t);
    m_dout = b;
    put(mk(0, 0, 1, 1, 1, 1, 0, 0), t);
    for (int i = 0; i < WL; i++) put(mk(0, 0, 0, 1, 1, 1, 0, 0), t);
    for (int i = 0; i < WH; i++) put(mk(0, 0, 1, 1, 1, 1, 0, 0), t);
  endtask

  task automatic issue(logic [2:0] k, logic [1:0] f, logic [23:0] w,
                       logic [7:0] din, string t);
    do begin @(posedge clk); #1; end while (eq.size() != 0);
    req_kind = k; req_fmt = f; req_word = w; lcd_din = din; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    case (k)
      3'd0: begin m_rs = 1'b0; push_byte(w[7:0], t); end
      3'd1: begin m_rs = 1'b1; push_byte(w[7:0], t); end
      3'd2: begin
        if (f == 2'd3) put(mk(1, 1, 1, 1, 1, 1, 1, 0), t);
        else begin
          m_rs = 1'b1;
          if (f == 2'd0) begin push_byte(w[23:16], t); push_byte(w[15:8], t); end
          if (f == 2'd1) begin push_byte({6'b0, w[17:16]}, t); push_byte(w[15:8], t); end
          if (f == 2'd2) push_byte(w[15:8], t);
          push_byte(w[7:0], t);
        end
      end
      3'd3: begin
        m_rs = 1'b1;
        for (int i = 0; i < RL; i++) put(mk(0, 0, 1, 0, 1, 0, 0, 0), t);
        m_rdb = din;
        for (int i = 0; i < RW; i++) put(mk(0, 0, 1, 1, 1, 0, 0, 0), t);
        put(mk(1, 1, 1, 1, 1, 1, 0, 1), t);
      end
      3'd4: begin
        for (int i = 0; i < XL; i++) put(mk(0, 1, 1, 1, 0, 1, 0, 0), t);
        for (int i = 0; i < XW; i++) put(mk(0, 1, 1, 1, 1, 1, 0, 0), t);
      end
      default: put(mk(1, 1, 1, 1, 1, 1, 1, 0), t);
    endcase
  endtask

  task automatic idle_gap(int n);
    do begin @(posedge clk); #1; end while (eq.size() != 0);
    repeat (n) @(posedge clk);
  endtask

  always @(negedge clk) begin
    logic [24:0] e;
    string t;
    if (rst_n) begin
      if (eq.size() != 0) begin e = eq.pop_front(); t = tq.pop_front(); end
      else begin e = mk(1, 1, 1, 1, 1, 1, 0, 0); t = "R7 R8"; end
      vectors++;
      if (got() !== e) begin
        errors++;
        $display("FAIL %s at %0t: got %h expected %h", t, $time, got(), e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    vectors++;
    if (got() !== mk(1, 1, 1, 1, 1, 1, 0, 0)) begin
      errors++;
      $display("FAIL R1 reset state: got %h expected %h", got(), mk(1, 1, 1, 1, 1, 1, 0, 0));
    end
    rst_n = 1'b1;
    issue(3'd0, 2'd0, 24'h00002A, 8'h00, "R2 R8 cmd");
    issue(3'd1, 2'd0, 24'h00005C, 8'h00, "R3 R8 data");
    issue(3'd2, 2'd0, 24'hA1B2C3, 8'h00, "R4 fmt0");
    issue(3'd2, 2'd1, 24'hFFFFFF, 8'h00, "R5 fmt1");
    issue(3'd2, 2'd2, 24'h12F81F, 8'h00, "R6 fmt2");
    idle_gap(5);
    issue(3'd0, 2'd0, 24'h000011, 8'h00, "R2 cmd after pixel");
    issue(3'd3, 2'd0, 24'h0, 8'h9D, "R9 read a");
    issue(3'd3, 2'd0, 24'h0, 8'h42, "R9 read b");
    issue(3'd2, 2'd1, 24'h02C0FE, 8'h00, "R5 fmt1 b");
    issue(3'd4, 2'd0, 24'h0, 8'h00, "R10 reset pulse");
    issue(3'd2, 2'd3, 24'h123456, 8'h00, "R11 bad format");
    issue(3'd6, 2'd0, 24'h0000AA, 8'h00, "R11 bad kind");
    issue(3'd1, 2'd0, 24'h000000, 8'h00, "R3 zero data");
    issue(3'd2, 2'd2, 24'h00FFE0, 8'h00, "R6 fmt2 b");
    issue(3'd2, 2'd0, 24'h00FF00, 8'h00, "R4 fmt0 b");
    idle_gap(8);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule